// File: doc/BRIEF.md
# Zero-Crossing Event Qualifier

This block decides when a back-EMF zero-crossing event of a sensorless brushless motor drive is valid. Each commutation event opens a blanking window. The window hides the switching noise that follows a phase change, so comparator activity during that time is discarded. The window length is chosen from sixteen settings. The short settings count a fine time unit and the long settings count a coarse unit, which is four fine units.

When the window has closed, the block looks at the raw comparator level on each sampling strobe. It counts how many of these samples in a row show the event. When the run reaches a programmable limit, a sticky zero-crossing flag is set. Firmware can request a simulated event, and such a request needs only a single sample. The flag stays set until firmware clears it or the next commutation arrives. Commutation can come from hardware or from software, and both sources act the same way.

Top module: `zc_qualifier`

## Requirements
- R1: A pulse on either `cmt_hw_i` or `cmt_sw_i` restarts the blanking window from zero, clears the consecutive-sample count, and clears `zc_flag_o` at the next clock edge. This also applies during a window that is already running.
- R2: While the blanking window is open, samples of `zc_raw_i` and `zc_sim_i` are ignored: the flag stays low and the count stays at zero.
- R3: The window length is latched from `win_sel_i` when commutation arrives. It is measured in `tick_i` pulses counted after the commutation. A code k from 0 to 7 needs k+1 pulses. A code k from 8 to 15 needs 4*(k-5) pulses: the coarse unit is 4 pulses, and the divider restarts at every commutation. Samples are valid from the cycle after the last required pulse.
- R4: Once the window has closed, the filter reacts only in cycles where `samp_en_i` is high. Comparator levels in other cycles neither add to the count nor reset it.
- R5: A sample taken with `zc_raw_i` low returns the consecutive count to zero.
- R6: The limit is `lim_sel_i`+1, which gives a range of 1 to 16. The flag rises at the edge of the sample that brings the consecutive count up to the limit. With code 0, the first sample with the event present sets it.
- R7: A sample taken with `zc_sim_i` high sets the flag at once, whatever the limit is.
- R8: The flag stays set until `flag_clr_i` or a commutation clears it. If a clear and a qualifying sample fall in the same cycle, the flag is set. After the flag has been set, further samples are ignored until the next commutation.
- R9: After reset the flag is low, and no sample is counted until the first commutation has opened and closed a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmt_hw_i | input | 1 | Hardware commutation strobe |
| cmt_sw_i | input | 1 | Software commutation strobe |
| tick_i | input | 1 | Fine time-unit enable |
| win_sel_i | input | 4 | Blanking window length code |
| lim_sel_i | input | 4 | Consecutive-sample limit code (limit = code+1) |
| samp_en_i | input | 1 | Sampling strobe |
| zc_raw_i | input | 1 | Raw comparator zero-crossing level |
| zc_sim_i | input | 1 | Simulated zero-crossing request |
| flag_clr_i | input | 1 | Flag clear |
| zc_flag_o | output | 1 | Sticky qualified zero-crossing flag |

## Verification
The hardest situation to reach is the exact cycle in which a long window closes. The coarse unit divider has to restart at each commutation, and a single extra or missing fine pulse must change the result. The bench stops one pulse short of the computed length while it keeps presenting event samples, and checks that the flag stays low. It then gives one more pulse and checks that the flag rises on the next sample. The same is done for a short code, a mid-range code and the longest code. A second hard case is a software commutation in the middle of a window. It must restart the count, so that pulses given before it do not count toward the window.

// File: rtl/zc_pkg.sv
package zc_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_BLANK  = 2'd1,
        PH_FILTER = 2'd2,
        PH_DONE   = 2'd3
    } phase_e;
endpackage

// File: rtl/zc_blank_timer.sv
module zc_blank_timer #(
    parameter int SEL_W   = 4,
    parameter int PRE_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             tick_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             expire_o
);
    localparam int PW   = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam int HALF = 2 ** (SEL_W - 1);
    localparam logic [SEL_W-1:0] COARSE_OFS = SEL_W'(HALF - 3);

    typedef struct packed {
        logic             run;
        logic             wide;
        logic [PW-1:0]    pre;
        logic [SEL_W-1:0] wcnt;
        logic [SEL_W-1:0] len;
    } tmr_s;

    tmr_s st_d, st_q;
    logic unit_tick;
    logic last_unit;

    always_comb begin
        unit_tick = tick_i && (!st_q.wide || (st_q.pre == PW'(PRE_DIV - 1)));
        last_unit = (st_q.wcnt == (st_q.len - SEL_W'(1)));
        expire_o  = st_q.run && unit_tick && last_unit;

        st_d = st_q;
        if (start_i) begin
            st_d.run  = 1'b1;
            st_d.wide = sel_i[SEL_W-1];
            st_d.pre  = '0;
            st_d.wcnt = '0;
            st_d.len  = sel_i[SEL_W-1] ? (sel_i - COARSE_OFS) : (sel_i + SEL_W'(1));
        end else if (st_q.run && tick_i) begin
            st_d.pre = (st_q.pre == PW'(PRE_DIV - 1)) ? '0 : st_q.pre + PW'(1);
            if (unit_tick) begin
                if (last_unit) st_d.run  = 1'b0;
                else           st_d.wcnt = st_q.wcnt + SEL_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/zc_debounce.sv
module zc_debounce #(
    parameter int SEL_W = 4,
    localparam int CW   = SEL_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic             raw_i,
    input  logic             sim_i,
    input  logic [SEL_W-1:0] lim_sel_i,
    output logic             hit_o,
    output logic [CW-1:0]    cnt_o
);
    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] cnt_inc;
    logic [CW-1:0] limit;

    always_comb begin
        cnt_inc = cnt_q + CW'(1);
        limit   = {1'b0, lim_sel_i} + CW'(1);
        hit_o   = en_i && (sim_i || (raw_i && (cnt_inc >= limit)));

        cnt_d = cnt_q;
        if (clr_i || hit_o) cnt_d = '0;
        else if (en_i)      cnt_d = raw_i ? cnt_inc : '0;
        cnt_o = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/zc_qualifier.sv
module zc_qualifier #(
    parameter int SEL_W   = 4,
    parameter int PRE_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmt_hw_i,
    input  logic             cmt_sw_i,
    input  logic             tick_i,
    input  logic [SEL_W-1:0] win_sel_i,
    input  logic [SEL_W-1:0] lim_sel_i,
    input  logic             samp_en_i,
    input  logic             zc_raw_i,
    input  logic             zc_sim_i,
    input  logic             flag_clr_i,
    output logic             zc_flag_o
);
    import zc_pkg::*;
    localparam int CW = SEL_W + 1;

    typedef struct packed {
        phase_e phase;
        logic   flag;
    } top_s;

    top_s          st_d, st_q;
    logic          cmt;
    logic          win_done;
    logic          filt_en;
    logic          hit;
    logic [CW-1:0] run_cnt;

    assign cmt     = cmt_hw_i || cmt_sw_i;
    assign filt_en = (st_q.phase == PH_FILTER) && samp_en_i && !cmt;

    zc_blank_timer #(.SEL_W(SEL_W), .PRE_DIV(PRE_DIV)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (cmt),
        .tick_i   (tick_i),
        .sel_i    (win_sel_i),
        .expire_o (win_done)
    );

    zc_debounce #(.SEL_W(SEL_W)) u_deb (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (cmt),
        .en_i      (filt_en),
        .raw_i     (zc_raw_i),
        .sim_i     (zc_sim_i),
        .lim_sel_i (lim_sel_i),
        .hit_o     (hit),
        .cnt_o     (run_cnt)
    );

    always_comb begin
        st_d = st_q;
        if (cmt) begin
            st_d.phase = PH_BLANK;
            st_d.flag  = 1'b0;
        end else begin
            if (flag_clr_i) st_d.flag = 1'b0;
            unique case (st_q.phase)
                PH_BLANK:  if (win_done) st_d.phase = PH_FILTER;
                PH_FILTER: if (hit) begin
                    st_d.phase = PH_DONE;
                    st_d.flag  = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.flag  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign zc_flag_o = st_q.flag;
endmodule

// File: rtl/zc_qualifier_chk.sv
module zc_qualifier_chk #(
    parameter int CW = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cmt_hw_i,
    input logic           cmt_sw_i,
    input logic           samp_en_i,
    input logic           zc_raw_i,
    input logic           zc_sim_i,
    input logic           flag_clr_i,
    input logic           zc_flag_o,
    input zc_pkg::phase_e phase,
    input logic [CW-1:0]  run_cnt
);
    import zc_pkg::*;

    assert_cmt_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_hw_i || cmt_sw_i) |=> (!zc_flag_o && run_cnt == '0));

    assert_blank_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_BLANK) |-> (!zc_flag_o && run_cnt == '0));

    assert_sample_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!samp_en_i && !cmt_hw_i && !cmt_sw_i) |=> $stable(run_cnt));

    assert_rise_needs_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(zc_flag_o) |-> $past(samp_en_i && (zc_raw_i || zc_sim_i)));

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (zc_flag_o && !flag_clr_i && !cmt_hw_i && !cmt_sw_i) |=> zc_flag_o);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> (!zc_flag_o && run_cnt == '0));
endmodule

bind zc_qualifier zc_qualifier_chk #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmt_hw_i   (cmt_hw_i),
    .cmt_sw_i   (cmt_sw_i),
    .samp_en_i  (samp_en_i),
    .zc_raw_i   (zc_raw_i),
    .zc_sim_i   (zc_sim_i),
    .flag_clr_i (flag_clr_i),
    .zc_flag_o  (zc_flag_o),
    .phase      (st_q.phase),
    .run_cnt    (run_cnt)
);

// File: tb/test_zc_qualifier.sv
module test_zc_qualifier;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmt_hw_i = 1'b0, cmt_sw_i = 1'b0, tick_i = 1'b0;
    logic [3:0] win_sel_i = 4'd0, lim_sel_i = 4'd0;
    logic       samp_en_i = 1'b0, zc_raw_i = 1'b0, zc_sim_i = 1'b0, flag_clr_i = 1'b0;
    logic       zc_flag_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    zc_qualifier i_zc_qualifier (
        .clk(clk), .rst_n(rst_n), .cmt_hw_i(cmt_hw_i), .cmt_sw_i(cmt_sw_i),
        .tick_i(tick_i), .win_sel_i(win_sel_i), .lim_sel_i(lim_sel_i),
        .samp_en_i(samp_en_i), .zc_raw_i(zc_raw_i), .zc_sim_i(zc_sim_i),
        .flag_clr_i(flag_clr_i), .zc_flag_o(zc_flag_o)
    );

    // {window code, limit code, consecutive event samples after window}
    localparam logic [15:0] VEC [8] = '{
        {4'd0,  4'd0,  8'd1},
        {4'd2,  4'd3,  8'd3},
        {4'd2,  4'd3,  8'd4},
        {4'd7,  4'd1,  8'd2},
        {4'd8,  4'd5,  8'd5},
        {4'd11, 4'd5,  8'd6},
        {4'd15, 4'd15, 8'd15},
        {4'd13, 4'd15, 8'd16}
    };

    function automatic int win_ticks(input int k);
        return (k < 8) ? k + 1 : 4 * (k - 5);
    endfunction

    task automatic step(input logic hw, input logic sw, input logic tk,
                        input logic se, input logic raw, input logic sim, input logic clr);
        @(negedge clk);
        cmt_hw_i = hw; cmt_sw_i = sw; tick_i = tk;
        samp_en_i = se; zc_raw_i = raw; zc_sim_i = sim; flag_clr_i = clr;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic check(input string req, input logic exp);
        n_chk++;
        if (zc_flag_o !== exp) begin
            n_fail++;
            $display("FAIL %s: zc_flag_o=%b expected %b", req, zc_flag_o, exp);
        end
    endtask

    // commutation, then the window is held open by n ticks while event samples are offered
    task automatic open_window(input logic [3:0] w, input int n);
        win_sel_i = w;
        step(1, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < n; i++) step(0, 0, 1, 1, 1, 1, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset", 1'b0);
        @(negedge clk); rst_n = 1'b1;
        // R9: no commutation yet, event samples ignored
        lim_sel_i = 4'd0;
        for (int i = 0; i < 4; i++) step(0, 0, 1, 1, 1, 1, 0);
        check("R9 before first commutation", 1'b0);

        // table walk: R2 (samples during window) R3 R6
        for (int v = 0; v < 8; v++) begin
            logic [3:0] w, l;
            int ns;
            w = VEC[v][15:12]; l = VEC[v][11:8]; ns = int'(VEC[v][7:0]);
            lim_sel_i = l;
            open_window(w, win_ticks(int'(w)));
            check("R2 window ignores samples", 1'b0);
            for (int i = 0; i < ns; i++) step(0, 0, 0, 1, 1, 0, 0);
            check("R6 limit reached", (ns >= int'(l) + 1) ? 1'b1 : 1'b0);
        end

        // R3: exact window edge, short, mid and longest codes
        for (int c = 0; c < 3; c++) begin
            logic [3:0] w;
            w = (c == 0) ? 4'd3 : (c == 1) ? 4'd9 : 4'd15;
            lim_sel_i = 4'd0;
            open_window(w, win_ticks(int'(w)) - 1);
            step(0, 0, 0, 1, 1, 0, 0);
            check("R3 one tick short", 1'b0);
            step(0, 0, 1, 0, 0, 0, 0);
            step(0, 0, 0, 1, 1, 0, 0);
            check("R3 window closed", 1'b1);
        end

        // R1: software commutation restarts a running window
        lim_sel_i = 4'd0;
        open_window(4'd3, 3);
        step(0, 1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0, 0, 0);
        step(0, 0, 0, 1, 1, 0, 0);
        check("R1 restart by sw commutation", 1'b0);
        step(0, 0, 1, 0, 0, 0, 0);
        step(0, 0, 0, 1, 1, 0, 0);
        check("R1 window after restart", 1'b1);
        step(1, 0, 0, 0, 0, 0, 0);
        check("R1 hw commutation clears flag", 1'b0);

        // R4: non-sample cycles neither count nor reset
        lim_sel_i = 4'd1;
        open_window(4'd0, 1);
        step(0, 0, 0, 1, 1, 0, 0);
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, 0, 0);
        check("R4 unsampled highs do not count", 1'b0);
        step(0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 1, 0, 0);
        check("R4 unsampled low does not reset", 1'b1);

        // R5: a low sample resets the run
        lim_sel_i = 4'd3;
        open_window(4'd1, 2);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 1, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 1, 0, 0);
        check("R5 low sample resets run", 1'b0);
        step(0, 0, 0, 1, 1, 0, 0);
        check("R5 full run after reset", 1'b1);

        // R7: simulated event ignores a large limit
        lim_sel_i = 4'd15;
        open_window(4'd0, 1);
        step(0, 0, 0, 0, 0, 1, 0);
        check("R7 sim needs a sample strobe", 1'b0);
        step(0, 0, 0, 1, 0, 1, 0);
        check("R7 simulated event", 1'b1);

        // R8: sticky, clear, clear vs set, no rearm after clear
        idle();
        check("R8 sticky", 1'b1);
        step(0, 0, 0, 0, 0, 0, 1);
        check("R8 clear", 1'b0);
        step(0, 0, 0, 1, 1, 1, 0);
        check("R8 no rearm without commutation", 1'b0);
        lim_sel_i = 4'd0;
        open_window(4'd0, 1);
        step(0, 0, 0, 1, 1, 0, 1);
        check("R8 set wins over clear", 1'b1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule